// File: doc/BRIEF.md
# Timed DAC Update Request Controller

This block paces a waveform output built from two DAC channels. A timer trigger marks each moment at which both channels must present a new sample. The trigger is active low and comes from one of two places: an internal timing line or an external pin. The block picks one of the two, finds its falling edge and answers each edge with a single-cycle load strobe that goes to both DACs at once. In the same cycle it raises a pending-request flag, which tells the host to supply the next sample pair.

The host can service that flag in three ways. It can poll the flag in the status word. It can enable an interrupt line, which then follows the flag until software writes the request-clear strobe. It can enable a DMA request, which also follows the flag; in that case a DMA acknowledge clears the flag without software action.

The block also watches the sample FIFO. If an update arrives while the FIFO reports empty, the data was not delivered in time. The block then records a sticky underrun error and raises an early DAC-complete indication. Both stay set until software clears them.

Top module: `dac_upd_req_ctrl`

## Requirements
- R1: When `src_sel` is 1, the trigger is taken from `int_trig_n`; when it is 0, it is taken from `ext_trig_n`. While the other line is selected, edges on the unselected line cause no strobe and do not change the status.
- R2: With default parameters, a fall on `ext_trig_n` sampled at clock edge k gives `dac_update` high and status bit0 set after clock edge k+2 (two synchronizer stages). A fall on `int_trig_n` sampled at edge k gives the same result after edge k+1 (one stage).
- R3: Each falling edge of the selected trigger produces exactly one `dac_update` pulse, one clock wide, no matter how long the trigger stays low. The pulse is issued in the same cycle that the request flag becomes 1.
- R4: `status` bit0 is the request flag. Once set, it stays 1 until a request-clear write or an enabled DMA acknowledge.
- R5: `irq` equals the request flag while `irq_en` is 1 and is 0 while `irq_en` is 0. The interrupt is removed only by `req_clr_wr`.
- R6: `dma_req` equals the request flag while `dma_en` is 1 and is 0 otherwise. `dma_ack` clears the flag when `dma_en` is 1 and has no effect on the flag when `dma_en` is 0.
- R7: `status` bit1 is the underrun error. It is set when an update occurs while `fifo_nempty_n` is 1 (FIFO empty). It is sticky, and it is cleared by `req_clr_wr` or by `dac_clr_wr`.
- R8: `status` bit2 is the early DAC-complete indication. It is set together with the underrun error and is cleared only by `dac_clr_wr`.
- R9: If an update and a clear (request-clear write, DAC-clear write or enabled DMA acknowledge) fall in the same cycle, the set wins. The request flag, and the error bit if the FIFO is empty, end that cycle at 1.
- R10: After reset, `status` is 0 and `dac_update`, `irq` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Trigger source: 1 internal line, 0 external pin |
| int_trig_n | input | 1 | Internal active-low timing line |
| ext_trig_n | input | 1 | External active-low trigger pin, asynchronous |
| irq_en | input | 1 | Interrupt servicing enable |
| dma_en | input | 1 | DMA servicing enable |
| req_clr_wr | input | 1 | Request-clear register write strobe |
| dac_clr_wr | input | 1 | DAC-clear register write strobe |
| dma_ack | input | 1 | DMA acknowledge |
| fifo_nempty_n | input | 1 | Active-low FIFO-not-empty; 1 means FIFO empty |
| dac_update | output | 1 | One-cycle load strobe to both DACs |
| status | output | 3 | bit0 request flag, bit1 underrun error, bit2 DAC-complete |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its default depths: two synchronizer stages on the external pin and one on the internal line. The scoreboard can therefore tell apart the three-edge and two-edge latencies of the two sources. It can also place a clear strobe exactly on the cycle in which the flag is set, which checks the set-wins rule for both the flag and the error bit. Long trigger pulses show that one edge gives one strobe. The two clear strobes are exercised separately, so the differing clear rules of the error bit and the DAC-complete bit can be seen.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

   // Status word layout: bit0 request, bit1 underrun, bit2 early complete
   typedef struct packed {
      logic done;
      logic err;
      logic req;
   } dur_status_t;

   localparam int STAT_W = $bits(dur_status_t);

endpackage

// File: rtl/dur_sync.sv
module dur_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_depth
      $error("dur_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= RST_VAL;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/dur_trig_front.sv
module dur_trig_front #(
   parameter int EXT_STAGES = 2,
   parameter int INT_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_sel,
   input  logic ext_n,
   input  logic int_n,
   output logic fall_o
);

   logic ext_s, int_s, sel_s, prev_q;

   dur_sync #(.STAGES(EXT_STAGES), .RST_VAL(1'b1)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_n), .q(ext_s)
   );

   dur_sync #(.STAGES(INT_STAGES), .RST_VAL(1'b1)) u_int_sync (
      .clk(clk), .rst_n(rst_n), .d(int_n), .q(int_s)
   );

   assign sel_s = src_sel ? int_s : ext_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sel_s;
   end

   assign fall_o = prev_q & ~sel_s;

   AST_ONE_EDGE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R3

endmodule

// File: rtl/dur_req_ctrl.sv
module dur_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic req_clr_i,
   input  logic dma_ack_i,
   input  logic irq_en_i,
   input  logic dma_en_i,
   output logic req_o,
   output logic upd_o,
   output logic irq_o,
   output logic dma_req_o
);

   logic req_q, upd_q, clr_any;

   assign clr_any = req_clr_i | (dma_ack_i & dma_en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= set_i;
         if (set_i)        req_q <= 1'b1;
         else if (clr_any) req_q <= 1'b0;
      end
   end

   assign req_o     = req_q;
   assign upd_o     = upd_q;
   assign irq_o     = irq_en_i & req_q;
   assign dma_req_o = dma_en_i & req_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> req_q); // R9

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !req_clr_i && !(dma_ack_i && dma_en_i)) |=> req_q); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en_i && dma_ack_i && !set_i) |=> !req_q); // R6

   AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !dma_en_i && !req_clr_i) |=> req_q); // R6

endmodule

// File: rtl/dur_underrun.sv
module dur_underrun (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic fifo_empty_i,
   input  logic req_clr_i,
   input  logic dac_clr_i,
   output logic err_o,
   output logic done_o
);

   logic err_q, done_q, hit;

   assign hit = set_i & fifo_empty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (hit)                         err_q <= 1'b1;
         else if (req_clr_i || dac_clr_i) err_q <= 1'b0;
         if (hit)                         done_q <= 1'b1;
         else if (dac_clr_i)              done_q <= 1'b0;
      end
   end

   assign err_o  = err_q;
   assign done_o = done_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !req_clr_i && !dac_clr_i) |=> err_q); // R7

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !dac_clr_i) |=> done_q); // R8

   AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (err_q && done_q)); // R9

endmodule

// File: rtl/dac_upd_req_ctrl.sv
module dac_upd_req_ctrl
   import dac_upd_pkg::*;
#(
   parameter int EXT_SYNC_STAGES = 2,
   parameter int INT_SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_sel,
   input  logic              int_trig_n,
   input  logic              ext_trig_n,
   input  logic              irq_en,
   input  logic              dma_en,
   input  logic              req_clr_wr,
   input  logic              dac_clr_wr,
   input  logic              dma_ack,
   input  logic              fifo_nempty_n,
   output logic              dac_update,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic              dma_req
);

   if (EXT_SYNC_STAGES < 2) begin : g_bad_ext
      $error("dac_upd_req_ctrl: external pin needs at least two sync stages");
   end
   if (INT_SYNC_STAGES < 1) begin : g_bad_int
      $error("dac_upd_req_ctrl: internal line needs at least one stage");
   end

   logic        fall;
   dur_status_t stat;

   dur_trig_front #(
      .EXT_STAGES(EXT_SYNC_STAGES),
      .INT_STAGES(INT_SYNC_STAGES)
   ) u_front (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .ext_n(ext_trig_n), .int_n(int_trig_n), .fall_o(fall)
   );

   dur_req_ctrl u_req (
      .clk(clk), .rst_n(rst_n), .set_i(fall),
      .req_clr_i(req_clr_wr), .dma_ack_i(dma_ack),
      .irq_en_i(irq_en), .dma_en_i(dma_en),
      .req_o(stat.req), .upd_o(dac_update),
      .irq_o(irq), .dma_req_o(dma_req)
   );

   dur_underrun u_urun (
      .clk(clk), .rst_n(rst_n), .set_i(fall),
      .fifo_empty_i(fifo_nempty_n), .req_clr_i(req_clr_wr),
      .dac_clr_i(dac_clr_wr), .err_o(stat.err), .done_o(stat.done)
   );

   assign status = stat;

   AST_STROBE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dac_update |-> status[0]); // R3

   AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      dac_update |=> !dac_update); // R3

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || dma_req) |-> status[0]); // R5

endmodule

// File: tb/dac_upd_req_ctrl_tb.sv
module dac_upd_req_ctrl_tb;

   typedef struct {
      int   due;
      logic err;
      logic done;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic src_sel = 1'b0, int_trig_n = 1'b1, ext_trig_n = 1'b1;
   logic irq_en = 1'b0, dma_en = 1'b0, req_clr_wr = 1'b0, dac_clr_wr = 1'b0;
   logic dma_ack = 1'b0, fifo_nempty_n = 1'b0;
   logic       dac_update, irq, dma_req;
   logic [2:0] status;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic prev_upd = 1'b0;
   exp_t q[$];

   dac_upd_req_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .int_trig_n(int_trig_n),
      .ext_trig_n(ext_trig_n), .irq_en(irq_en), .dma_en(dma_en),
      .req_clr_wr(req_clr_wr), .dac_clr_wr(dac_clr_wr), .dma_ack(dma_ack),
      .fifo_nempty_n(fifo_nempty_n), .dac_update(dac_update), .status(status),
      .irq(irq), .dma_req(dma_req)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: every strobe must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (dac_update && prev_upd) chk("R3 strobe width", 32'd2, 32'd1);
         if (dac_update) begin
            if (q.size() == 0) begin
               chk("R1/R3 unexpected strobe", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk("R2 strobe cycle", cyc, e.due);
               chk("R3 flag with strobe", {31'd0, status[0]}, 32'd1);
               chk("R7 err at strobe", {31'd0, status[1]}, {31'd0, e.err});
               chk("R8 done at strobe", {31'd0, status[2]}, {31'd0, e.done});
            end
         end
      end
      prev_upd = dac_update;
   end

   // Driver: one trigger pulse of a given low width; pushes expected item
   task automatic trig(input logic use_int, input int width, input logic e_err, input logic e_done);
      exp_t e;
      @(negedge clk);
      e.due  = cyc + (use_int ? 2 : 3);
      e.err  = e_err;
      e.done = e_done;
      q.push_back(e);
      if (use_int) int_trig_n = 1'b0; else ext_trig_n = 1'b0;
      repeat (width) @(negedge clk);
      int_trig_n = 1'b1;
      ext_trig_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse_clr(input logic rq, input logic dc, input logic ak);
      @(negedge clk);
      req_clr_wr = rq; dac_clr_wr = dc; dma_ack = ak;
      @(negedge clk);
      req_clr_wr = 1'b0; dac_clr_wr = 1'b0; dma_ack = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 status", {29'd0, status}, 32'd0);
      chk("R10 outputs", {29'd0, dac_update, irq, dma_req}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4: external source, long pulse, polled
      trig(1'b0, 8, 1'b0, 1'b0);
      chk("R4 flag held", {31'd0, status[0]}, 32'd1);
      chk("R5 irq gated off", {31'd0, irq}, 32'd0);
      chk("R6 dma gated off", {31'd0, dma_req}, 32'd0);
      pulse_clr(1'b1, 1'b0, 1'b0);
      chk("R4 cleared", {31'd0, status[0]}, 32'd0);

      // R5 interrupt path; ack ignored without dma_en
      irq_en = 1'b1;
      trig(1'b0, 2, 1'b0, 1'b0);
      chk("R5 irq follows flag", {31'd0, irq}, 32'd1);
      pulse_clr(1'b0, 1'b0, 1'b1);
      chk("R6 ack ignored", {30'd0, status[0], irq}, 32'd3);
      pulse_clr(1'b1, 1'b0, 1'b0);
      chk("R5 irq cleared", {31'd0, irq}, 32'd0);

      // R6 DMA path
      irq_en = 1'b0; dma_en = 1'b1;
      trig(1'b0, 3, 1'b0, 1'b0);
      chk("R6 dma_req", {30'd0, dma_req, irq}, 32'd2);
      pulse_clr(1'b0, 1'b0, 1'b1);
      chk("R6 ack clears", {30'd0, status[0], dma_req}, 32'd0);

      // R5 R6 both enabled
      irq_en = 1'b1;
      trig(1'b0, 1, 1'b0, 1'b0);
      chk("R5 R6 both follow", {30'd0, irq, dma_req}, 32'd3);
      pulse_clr(1'b1, 1'b0, 1'b0);
      irq_en = 1'b0; dma_en = 1'b0;

      // R1 internal source; external edge ignored
      src_sel = 1'b1;
      repeat (2) @(negedge clk);
      ext_trig_n = 1'b0;
      repeat (6) @(negedge clk);
      ext_trig_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R1 unselected ignored", {29'd0, status}, 32'd0);
      trig(1'b1, 6, 1'b0, 1'b0);
      chk("R1 internal sets flag", {31'd0, status[0]}, 32'd1);
      pulse_clr(1'b1, 1'b0, 1'b0);

      // R7 R8 underrun
      fifo_nempty_n = 1'b1;
      trig(1'b1, 2, 1'b1, 1'b1);
      pulse_clr(1'b1, 1'b0, 1'b0);
      chk("R7 err cleared by req clr", {29'd0, status}, 32'd4);
      trig(1'b1, 2, 1'b1, 1'b1);
      pulse_clr(1'b0, 1'b1, 1'b0);
      chk("R8 dac clr clears err/done", {29'd0, status}, 32'd1);
      pulse_clr(1'b1, 1'b0, 1'b0);
      chk("R4 idle", {29'd0, status}, 32'd0);

      // R9 set wins: clear lands in the cycle the flag is set
      dma_en = 1'b1;
      begin
         exp_t e;
         @(negedge clk);
         e.due = cyc + 2; e.err = 1'b1; e.done = 1'b1;
         q.push_back(e);
         int_trig_n = 1'b0;
         @(negedge clk);
         req_clr_wr = 1'b1; dma_ack = 1'b1;
         @(negedge clk);
         req_clr_wr = 1'b0; dma_ack = 1'b0;
         chk("R9 set wins flag/err", {29'd0, status}, 32'd7);
         int_trig_n = 1'b1;
         repeat (5) @(negedge clk);
      end
      chk("R9 flag still set", {31'd0, status[0]}, 32'd1);

      chk("R3 scoreboard drained", q.size(), 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule